// File: doc/BRIEF.md
# Daisy-Chain DAC Frame Transmitter

This block is the host-side serial master for a string of serial DACs that share one serial clock and one chip-select/load line, with each device's data output wired to the data input of the next. A request carries one command and one 16-bit data word for every device, plus an enable bit per device. The block builds a 32-bit frame per device and joins the frames into one stream. It shifts the stream out so that every device holds its own frame when the load line rises, and all devices then act at the same moment.

Devices whose enable bit is clear receive the no-operation code, so one device can be written on its own. The serial clock runs at a rate set by a divider parameter. While the stream goes out, the data that returns from the far end of the chain is captured bit by bit. That data is the stream the chain held before this transaction, and it is presented when the transaction completes.

Top module: `dchain_dac_tx`

## Requirements
- R1: Each device frame is 32 bits sent MSB first: bits 31..24 are zero, bits 23..20 carry the 4-bit command unchanged (0000 load input, 0001 update output, 0011 load and update, 0100 power down), bits 19..16 are zero, and bits 15..0 carry the data word.
- R2: The frame for device NDEV-1 (farthest from the host) goes out first and the frame for device 0 goes out last, so after the transaction device k holds the frame built from request slot k.
- R3: A device whose `req_en` bit is 0 receives the frame with command 1111 and all other bits zero.
- R4: `sck` idles low, `cs_ld` falls before the first rising edge of `sck`, and `cs_ld` stays low whenever `sck` is high.
- R5: One transaction gives exactly NDEV*32 rising edges of `sck` while `cs_ld` is low, followed by a single rise of `cs_ld`.
- R6: `sdi` changes only while `sck` is low. It holds its value for the whole high phase of every `sck` pulse.
- R7: Each high phase and each low phase of `sck` lasts DIV clock cycles.
- R8: `cs_ld` stays high for at least 2*DIV clock cycles between two transactions.
- R9: A `start` seen while idle begins a transaction and `busy` is high from the next cycle until the cycle `done` is asserted. A `start` seen while `busy` is high is ignored and produces no transaction.
- R10: `done` is a one-cycle pulse. From that cycle `rx_data` holds the NDEV*32 bits sampled from `sdo_in` at each `sck` rising edge, with the first sampled bit in the MSB. It stays unchanged until the next `done`.
- R11: After reset `cs_ld` is 1 and `sck`, `sdi`, `busy`, `done` and `rx_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transaction with the current request |
| req_en | input | NDEV | Per-device enable; clear means no-operation |
| req_cmd | input | NDEV*4 | Command per device, slot k at bits 4k+3..4k |
| req_data | input | NDEV*16 | Data per device, slot k at bits 16k+15..16k |
| sdo_in | input | 1 | Serial data returning from the last device |
| cs_ld | output | 1 | Chip select, low while shifting; rising edge executes |
| sck | output | 1 | Serial clock |
| sdi | output | 1 | Serial data to the first device |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | NDEV*32 | Stream returned from the chain, first bit in MSB |

## Verification
The assertions check the serial waveform rules on every cycle. These are data stability across the clock high phase, the load line held low under every clock pulse, the exact count of clock rises per load window, the minimum high time of the load line, and the single-cycle done pulse. Frame content, frame order, the no-op fill and the returned stream can only be shown by the bench's chain model. It shifts the stream through one register per device, decodes each device's command when the load line rises, and compares device state and returned data against values computed from the requests.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int unsigned CMD_W   = 4;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned FRAME_W = 32;
  localparam logic [CMD_W-1:0] CMD_NOP = 4'b1111;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LO   = 3'd1,
    ST_HI   = 3'd2,
    ST_TAIL = 3'd3,
    ST_GAP  = 3'd4
  } ctl_state_t;

  // Frame layout: 8 zero pad bits, command, 4 zero pad bits, data.
  function automatic logic [FRAME_W-1:0] make_frame(input logic [CMD_W-1:0] c,
                                                    input logic [DATA_W-1:0] d);
    return {8'h00, c, 4'h0, d};
  endfunction
endpackage

// File: rtl/dct_frame_asm.sv
module dct_frame_asm
  import dct_pkg::*;
#(
  parameter int unsigned NDEV = 4
) (
  input  logic [NDEV-1:0]        en,
  input  logic [NDEV*CMD_W-1:0]  cmd_vec,
  input  logic [NDEV*DATA_W-1:0] data_vec,
  output logic [NDEV*FRAME_W-1:0] stream
);
  // Slot k sits at bits 32k+31..32k; the highest slot leaves first.
  for (genvar k = 0; k < NDEV; k++) begin : g_slot
    always_comb begin
      if (en[k])
        stream[k*FRAME_W +: FRAME_W] = make_frame(cmd_vec[k*CMD_W +: CMD_W],
                                                  data_vec[k*DATA_W +: DATA_W]);
      else
        stream[k*FRAME_W +: FRAME_W] = make_frame(CMD_NOP, '0);
    end
  end
endmodule

// File: rtl/dct_sck_gen.sv
module dct_sck_gen #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt_q <= '0;
    else if (cnt_q == LAST)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/dct_shifter.sv
module dct_shifter #(
  parameter int unsigned W = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         advance,
  input  logic         sample,
  input  logic         ser_in,
  output logic         ser_out,
  output logic [W-1:0] rx_vec
);
  logic [W-1:0] tx_q;
  logic [W-1:0] rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q <= '0;
    end else if (load) begin
      tx_q <= load_val;
    end else if (advance) begin
      tx_q <= {tx_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rx_q <= '0;
    else if (sample)
      rx_q <= {rx_q[W-2:0], ser_in};
  end

  assign ser_out = tx_q[W-1];
  assign rx_vec  = rx_q;
endmodule

// File: rtl/dct_ctrl.sv
module dct_ctrl
  import dct_pkg::*;
#(
  parameter int unsigned NBITS = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic tick,
  output logic run,
  output logic load,
  output logic advance,
  output logic sample,
  output logic capture,
  output logic cs_ld,
  output logic sck,
  output logic busy,
  output logic done
);
  localparam int unsigned BW = $clog2(NBITS);
  localparam logic [BW-1:0] LAST_BIT = BW'(NBITS - 1);

  ctl_state_t state_q, state_d;
  logic [BW-1:0] bit_q;
  logic          gap_q;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    advance = 1'b0;
    sample  = 1'b0;
    capture = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        load    = 1'b1;
        state_d = ST_LO;
      end
      ST_LO: if (tick) begin
        sample  = 1'b1;
        state_d = ST_HI;
      end
      ST_HI: if (tick) begin
        if (bit_q == LAST_BIT) begin
          state_d = ST_TAIL;
        end else begin
          advance = 1'b1;
          state_d = ST_LO;
        end
      end
      ST_TAIL: if (tick) state_d = ST_GAP;
      ST_GAP: if (tick && gap_q) begin
        capture = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign run = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      gap_q   <= 1'b0;
      cs_ld   <= 1'b1;
      sck     <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= capture;
      if (load)
        bit_q <= '0;
      else if (advance)
        bit_q <= bit_q + 1'b1;
      if (state_q == ST_TAIL)
        gap_q <= 1'b0;
      else if (state_q == ST_GAP && tick)
        gap_q <= 1'b1;
      if (load)
        cs_ld <= 1'b0;
      else if (state_q == ST_TAIL && tick)
        cs_ld <= 1'b1;
      if (sample)
        sck <= 1'b1;
      else if (state_q == ST_HI && tick)
        sck <= 1'b0;
      if (load)
        busy <= 1'b1;
      else if (capture)
        busy <= 1'b0;
    end
  end
endmodule

// File: rtl/dchain_dac_tx.sv
module dchain_dac_tx
  import dct_pkg::*;
#(
  parameter int unsigned NDEV = 4,
  parameter int unsigned DIV  = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [NDEV-1:0]           req_en,
  input  logic [NDEV*CMD_W-1:0]     req_cmd,
  input  logic [NDEV*DATA_W-1:0]    req_data,
  input  logic                      sdo_in,
  output logic                      cs_ld,
  output logic                      sck,
  output logic                      sdi,
  output logic                      busy,
  output logic                      done,
  output logic [NDEV*FRAME_W-1:0]   rx_data
);
  localparam int unsigned NBITS = NDEV * FRAME_W;

  logic [NBITS-1:0] stream;
  logic [NBITS-1:0] rx_vec;
  logic run, tick, load, advance, sample, capture;

  dct_frame_asm #(.NDEV(NDEV)) u_asm (
    .en(req_en), .cmd_vec(req_cmd), .data_vec(req_data), .stream(stream)
  );

  dct_sck_gen #(.DIV(DIV)) u_div (
    .clk(clk), .rst(rst), .run(run), .tick(tick)
  );

  dct_ctrl #(.NBITS(NBITS)) u_ctl (
    .clk(clk), .rst(rst), .start(start), .tick(tick), .run(run),
    .load(load), .advance(advance), .sample(sample), .capture(capture),
    .cs_ld(cs_ld), .sck(sck), .busy(busy), .done(done)
  );

  dct_shifter #(.W(NBITS)) u_shf (
    .clk(clk), .rst(rst), .load(load), .load_val(stream), .advance(advance),
    .sample(sample), .ser_in(sdo_in), .ser_out(sdi), .rx_vec(rx_vec)
  );

  always_ff @(posedge clk) begin
    if (rst)
      rx_data <= '0;
    else if (capture)
      rx_data <= rx_vec;
  end
endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
  parameter int unsigned NDEV = 4,
  parameter int unsigned DIV  = 2
) (
  input logic clk,
  input logic rst,
  input logic cs_ld,
  input logic sck,
  input logic sdi,
  input logic busy,
  input logic done
);
  localparam logic [31:0] NRISE = 32'(NDEV * 32);
  localparam logic [31:0] GAPMIN = 32'(2 * DIV);

  logic        sck_q;
  logic [31:0] rise_cnt;
  logic [31:0] high_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q    <= 1'b0;
      rise_cnt <= '0;
      high_cnt <= GAPMIN;
    end else begin
      sck_q <= sck;
      if (cs_ld)
        rise_cnt <= '0;
      else if (sck && !sck_q)
        rise_cnt <= rise_cnt + 1;
      if (!cs_ld)
        high_cnt <= '0;
      else if (high_cnt < GAPMIN)
        high_cnt <= high_cnt + 1;
    end
  end

  a_r6_sdi_stable: assert property (@(posedge clk) disable iff (rst)
    (sck && $past(sck)) |-> $stable(sdi));
  a_r4_cs_low_under_sck: assert property (@(posedge clk) disable iff (rst)
    sck |-> !cs_ld);
  a_r5_rise_count: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_ld) |-> (rise_cnt == NRISE));
  a_r8_cs_high_time: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_ld) |-> (high_cnt >= GAPMIN));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
endmodule

bind dchain_dac_tx dct_checker #(.NDEV(NDEV), .DIV(DIV)) u_chk (
  .clk(clk), .rst(rst), .cs_ld(cs_ld), .sck(sck), .sdi(sdi),
  .busy(busy), .done(done)
);

// File: tb/sim_dchain_dac_tx.sv
`timescale 1ns/1ps
module sim_dchain_dac_tx;
  localparam int CLK_PERIOD = 10;
  localparam int NDEV = 3;
  localparam int DIV  = 2;
  localparam int NB   = NDEV * 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [NDEV-1:0]    req_en = '0;
  logic [NDEV*4-1:0]  req_cmd = '0;
  logic [NDEV*16-1:0] req_data = '0;
  logic sdo_q = 1'b0;
  logic cs_ld, sck, sdi, busy, done;
  logic [NB-1:0] rx_data;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dchain_dac_tx #(.NDEV(NDEV), .DIV(DIV)) u0 (
    .clk(clk), .rst(rst), .start(start), .req_en(req_en), .req_cmd(req_cmd),
    .req_data(req_data), .sdo_in(sdo_q), .cs_ld(cs_ld), .sck(sck), .sdi(sdi),
    .busy(busy), .done(done), .rx_data(rx_data)
  );

  // Chain model: one 32-bit register per device, device 0 nearest the host.
  logic [NB-1:0] chain = '0;
  logic [15:0] dv_in  [NDEV];
  logic [15:0] dv_out [NDEV];
  logic        dv_pd  [NDEV];
  logic [15:0] ex_in  [NDEV];
  logic [15:0] ex_out [NDEV];
  logic        ex_pd  [NDEV];
  logic [NB-1:0] prev_stream = '0;
  bit armed = 1'b0;
  int rises = 0, cs_falls = 0, sdi_bad = 0, cs_bad = 0;
  longint t_rise = 0, t_csrise = 0, hi_min = 1000, hi_max = 0, gap_min = 1000;
  bit have_csrise = 1'b0;

  initial for (int k = 0; k < NDEV; k++) begin
    dv_in[k] = '0; dv_out[k] = '0; dv_pd[k] = 1'b0;
    ex_in[k] = '0; ex_out[k] = '0; ex_pd[k] = 1'b0;
  end

  always @(posedge sck) begin
    chain <= {chain[NB-2:0], sdi};
    rises++;
    if (cs_ld) cs_bad++;
    t_rise = $time;
  end
  always @(negedge sck) begin
    longint w;
    sdo_q <= chain[NB-1];
    w = ($time - t_rise) / CLK_PERIOD;
    if (w < hi_min) hi_min = w;
    if (w > hi_max) hi_max = w;
  end
  always @(sdi) if (sck === 1'b1) sdi_bad++;
  always @(negedge cs_ld) if (!rst) begin
    armed = 1'b1;
    cs_falls++;
    rises = 0;
    if (have_csrise && (($time - t_csrise) / CLK_PERIOD) < gap_min)
      gap_min = ($time - t_csrise) / CLK_PERIOD;
  end
  always @(posedge cs_ld) if (armed) begin
    t_csrise = $time;
    have_csrise = 1'b1;
    for (int k = 0; k < NDEV; k++) begin
      logic [3:0] c;
      logic [15:0] d;
      c = chain[k*32+20 +: 4];
      d = chain[k*32 +: 16];
      case (c)
        4'b0000: dv_in[k] = d;
        4'b0001: begin dv_out[k] = dv_in[k]; dv_pd[k] = 1'b0; end
        4'b0011: begin dv_in[k] = d; dv_out[k] = d; dv_pd[k] = 1'b0; end
        4'b0100: dv_pd[k] = 1'b1;
        default: ;
      endcase
    end
  end

  function automatic logic [NB-1:0] build_stream(input logic [NDEV-1:0] en,
      input logic [NDEV*4-1:0] cm, input logic [NDEV*16-1:0] dt);
    logic [NB-1:0] s;
    for (int k = 0; k < NDEV; k++)
      s[k*32 +: 32] = en[k] ? {8'h00, cm[k*4 +: 4], 4'h0, dt[k*16 +: 16]}
                            : {8'h00, 4'b1111, 20'h0};
    return s;
  endfunction

  task automatic apply_exp(input logic [NDEV-1:0] en,
      input logic [NDEV*4-1:0] cm, input logic [NDEV*16-1:0] dt);
    for (int k = 0; k < NDEV; k++) if (en[k]) begin
      case (cm[k*4 +: 4])
        4'b0000: ex_in[k] = dt[k*16 +: 16];
        4'b0001: begin ex_out[k] = ex_in[k]; ex_pd[k] = 1'b0; end
        4'b0011: begin ex_in[k] = dt[k*16 +: 16]; ex_out[k] = dt[k*16 +: 16]; ex_pd[k] = 1'b0; end
        4'b0100: ex_pd[k] = 1'b1;
        default: ;
      endcase
    end
  endtask

  task automatic chk(input bit ok, input string tag,
      input logic [NB-1:0] act, input logic [NB-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_devices(input string tag);
    for (int k = 0; k < NDEV; k++) begin
      chk(dv_in[k] === ex_in[k], tag, NB'(dv_in[k]), NB'(ex_in[k]));
      chk(dv_out[k] === ex_out[k], tag, NB'(dv_out[k]), NB'(ex_out[k]));
      chk(dv_pd[k] === ex_pd[k], tag, NB'(dv_pd[k]), NB'(ex_pd[k]));
    end
  endtask

  task automatic wait_done();
    do @(negedge clk); while (done !== 1'b1);
  endtask

  task automatic finish_txn(input logic [NDEV-1:0] en,
      input logic [NDEV*4-1:0] cm, input logic [NDEV*16-1:0] dt);
    logic [NB-1:0] snap;
    // R10: returned stream equals what the chain held before.
    chk(rx_data === prev_stream, "R10 rx_data", rx_data, prev_stream);
    chk(rises == NB, "R5 rise count", NB'(rises), NB'(NB));
    snap = rx_data;
    apply_exp(en, cm, dt);
    prev_stream = build_stream(en, cm, dt);
    // R1 R2 R3: each device decoded its own frame.
    check_devices("R1/R2/R3 device state");
    @(negedge clk);
    chk(done === 1'b0, "R10 done pulse", NB'(done), '0);
    chk(rx_data === snap, "R10 rx_data hold", rx_data, snap);
  endtask

  task automatic run_txn(input logic [NDEV-1:0] en,
      input logic [NDEV*4-1:0] cm, input logic [NDEV*16-1:0] dt);
    while (busy) @(negedge clk);
    req_en = en; req_cmd = cm; req_data = dt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R9 busy after start", NB'(busy), NB'(1));
    wait_done();
    finish_txn(en, cm, dt);
  endtask

  function automatic logic [3:0] rand_cmd();
    case ($urandom % 4)
      0: return 4'b0000;
      1: return 4'b0001;
      2: return 4'b0011;
      default: return 4'b0100;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2601));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(cs_ld === 1'b1 && sck === 1'b0 && sdi === 1'b0, "R11 pins", NB'({cs_ld, sck, sdi}), NB'(3'b100));
    chk(busy === 1'b0 && done === 1'b0, "R11 status", NB'({busy, done}), '0);
    chk(rx_data === '0, "R11 rx_data", rx_data, '0);

    // All devices load and update with distinct data.
    run_txn('1, {4'b0011, 4'b0011, 4'b0011}, {16'hC3A5, 16'h8001, 16'h7FFE});
    // Only device 1 loads its input register; others get no-op (R3).
    run_txn(3'b010, {4'b0011, 4'b0000, 4'b0011}, {16'hFFFF, 16'h1234, 16'hFFFF});
    // Only device 1 updates.
    run_txn(3'b010, {4'b0000, 4'b0001, 4'b0000}, {16'h0, 16'h0, 16'h0});
    // Device 0 powers down, device 2 loads full scale.
    run_txn(3'b101, {4'b0000, 4'b0000, 4'b0100}, {16'hFFFF, 16'h0, 16'h0});
    // Update all, clearing power down.
    run_txn('1, {4'b0001, 4'b0001, 4'b0001}, '0);
    // No device addressed: every frame is a no-op.
    run_txn('0, {4'b0011, 4'b0011, 4'b0011}, {16'hAAAA, 16'hBBBB, 16'hCCCC});

    // R9: start while busy is ignored.
    begin
      int falls0;
      logic [NDEV-1:0] en_a;
      logic [NDEV*4-1:0] cm_a;
      logic [NDEV*16-1:0] dt_a;
      en_a = 3'b100; cm_a = {4'b0011, 4'b0000, 4'b0000}; dt_a = {16'h5A5A, 16'h0, 16'h0};
      falls0 = cs_falls;
      req_en = en_a; req_cmd = cm_a; req_data = dt_a; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (20) @(negedge clk);
      req_en = '1; req_cmd = {4'b0011, 4'b0011, 4'b0011}; req_data = {16'h1111, 16'h2222, 16'h3333};
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      req_en = en_a; req_cmd = cm_a; req_data = dt_a;
      wait_done();
      finish_txn(en_a, cm_a, dt_a);
      repeat (4 * NB * DIV) @(negedge clk);
      chk(cs_falls == falls0 + 1, "R9 ignored start", NB'(cs_falls - falls0), NB'(1));
      chk(busy === 1'b0, "R9 idle after ignored start", NB'(busy), '0);
    end

    // Random requests, issued back to back.
    for (int n = 0; n < 24; n++) begin
      logic [NDEV-1:0] en;
      logic [NDEV*4-1:0] cm;
      logic [NDEV*16-1:0] dt;
      en = NDEV'($urandom);
      for (int k = 0; k < NDEV; k++) begin
        cm[k*4 +: 4] = rand_cmd();
        dt[k*16 +: 16] = 16'($urandom);
      end
      run_txn(en, cm, dt);
    end

    chk(hi_min == DIV && hi_max == DIV, "R7 sck high width", NB'(hi_max), NB'(DIV));
    chk(gap_min >= 2 * DIV, "R8 cs high gap", NB'(gap_min), NB'(2 * DIV));
    chk(sdi_bad == 0, "R6 sdi moved while sck high", NB'(sdi_bad), '0);
    chk(cs_bad == 0, "R4 sck rose with cs high", NB'(cs_bad), '0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule